// File: doc/BRIEF.md
# Interrupt Target Dispatcher

This block turns one interrupt delivery request into a series of injections aimed at up to `NUM_TGT` processor targets. A request names a vector, a destination byte, whether that byte is a physical or a logical address, a delivery mode and a trigger kind. The block accepts it and builds a target set from three per-target inputs: a presence bit, a physical-address hit and a logical-address hit. The address comparators that produce the hit bits sit inside the targets and are not part of this block.

The delivery mode decides what is done with the set. Fixed delivery issues one injection to every member of the set, lowest id first. Lowest-priority delivery issues a single injection to one member, picked by a rotating pointer so that repeated requests spread across the candidates. Each injection carries the target id, the vector and the trigger kind, and waits on a ready/valid handshake. The block takes a new request only once every injection of the previous one has been taken.

Top module: `intr_dispatch`

## Requirements
- R1: After reset `req_ready` is 1, `inj_valid` is 0 and the rotating pointer is at target 0.
- R2: With `req_dest_logical`=0 and `req_dest`=8'hFF, the set is every target whose `tgt_present` bit is 1.
- R3: With `req_dest_logical`=0 and any other destination, the set holds only the lowest-id target that is both present and has its `tgt_phys_hit` bit set, or nothing if no target qualifies.
- R4: With `req_dest_logical`=1 and `req_dest`=0, the set is empty whatever the hit inputs are.
- R5: With `req_dest_logical`=1 and a non-zero destination, the set is every target that is present and has its `tgt_logic_hit` bit set.
- R6: A request whose set is empty is accepted and dropped: no injection follows and `req_ready` stays 1.
- R7: With `req_mode`=3'b000 (fixed), one injection per member of the set is issued in strictly ascending target id, each carrying the request's `req_vector` and `req_level`.
- R8: With `req_mode`=3'b001 (lowest priority), exactly one injection is issued, to the first member at or above the pointer, wrapping to the lowest member if none is; the pointer then moves to the chosen id plus one (wrapping to 0 after the last target).
- R9: A request with any other `req_mode` value is accepted and ignored: no injection is issued and the rotating pointer is unchanged.
- R10: While injections remain, `req_ready` is 0, and an offered injection keeps its target, vector and trigger unchanged until `inj_ready` is 1; `req_ready` returns to 1 in the cycle after the last injection is taken.
- R11: An injection appears on the port in the cycle after the request is accepted, and each following injection in the cycle after the previous one is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A delivery request is offered |
| req_ready | output | 1 | Block is idle and takes a request |
| req_vector | input | VEC_W | Vector to deliver |
| req_dest | input | DEST_W | Destination byte |
| req_dest_logical | input | 1 | 0 = physical destination, 1 = logical destination |
| req_mode | input | 3 | Delivery mode: 000 fixed, 001 lowest priority, others ignored |
| req_level | input | 1 | Trigger kind passed through (1 = level) |
| tgt_present | input | NUM_TGT | Target exists and can receive |
| tgt_phys_hit | input | NUM_TGT | Target's physical address equals the request destination |
| tgt_logic_hit | input | NUM_TGT | Target's logical address matches the request destination |
| inj_valid | output | 1 | An injection is offered |
| inj_ready | input | 1 | The injection is taken |
| inj_target | output | TID_W | Id of the receiving target |
| inj_vector | output | VEC_W | Vector of the injection |
| inj_level | output | 1 | Trigger kind of the injection |

## Verification
A wrong pending set shows within one cycle of acceptance as a missing, extra or out-of-order `inj_target`, or as `req_ready` staying low after the expected number of handshakes. A corrupted rotating pointer stays hidden until the next lowest-priority request, which then names the wrong target; the bench therefore runs back-to-back lowest-priority requests, with ignored-mode and dropped requests between them, so that a pointer disturbed by the wrong request surfaces on the very next pick. Random stalls on `inj_ready` expose any injection that changes or advances while it waits.

// File: rtl/intr_dispatch_pkg.sv
// Shared constants for the interrupt target dispatcher.
// Assumes a three-bit delivery mode field and an eight-bit destination byte.
package intr_dispatch_pkg;
    localparam logic [2:0] MODE_FIXED  = 3'b000;
    localparam logic [2:0] MODE_LOWEST = 3'b001;
    localparam logic [7:0] DEST_ALL    = 8'hFF;
endpackage

// File: rtl/intr_low_pick.sv
// Finds the lowest set bit of a vector.
// Assumes WIDTH >= 1; idx is 0 when nothing is set.
module intr_low_pick #(
    parameter int WIDTH = 32,
    localparam int IW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] bits,
    output logic             found,
    output logic [IW-1:0]    idx
);
    // scan from the top so the lowest set bit is written last
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/intr_target_mask.sv
// Builds the set of targets named by a request's destination.
// Assumes the hit inputs already compare each target's own address with
// the current destination byte; presence gates every candidate.
module intr_target_mask
    import intr_dispatch_pkg::*;
#(
    parameter int NUM_TGT = 32,
    parameter int DEST_W  = 8
) (
    input  logic [DEST_W-1:0]  dest,
    input  logic               logical,
    input  logic [NUM_TGT-1:0] present,
    input  logic [NUM_TGT-1:0] phys_hit,
    input  logic [NUM_TGT-1:0] logic_hit,
    output logic [NUM_TGT-1:0] mask
);
    localparam int IW = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;

    logic [NUM_TGT-1:0] phys_cand;
    logic [NUM_TGT-1:0] log_cand;
    logic [NUM_TGT-1:0] phys_first;
    logic               first_found;
    logic [IW-1:0]      first_idx;

    // per-target candidacy in each addressing scheme
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
        assign phys_cand[t] = present[t] & phys_hit[t];
        assign log_cand[t]  = present[t] & logic_hit[t];
    end

    intr_low_pick #(.WIDTH(NUM_TGT)) u_first (
        .bits  (phys_cand),
        .found (first_found),
        .idx   (first_idx)
    );

    // physical addressing selects only the first hit
    assign phys_first = first_found ? (NUM_TGT'(1) << first_idx) : '0;

    // choose the set according to the addressing scheme and destination
    always_comb begin
        if (!logical) begin
            mask = (dest == DEST_W'(DEST_ALL)) ? present : phys_first;
        end else begin
            mask = (dest == '0) ? '0 : log_cand;
        end
    end
endmodule

// File: rtl/intr_rr_pick.sv
// Rotating pick: first candidate at or above ptr, else the lowest candidate.
// Assumes ptr < NUM_TGT.
module intr_rr_pick #(
    parameter int NUM_TGT = 32,
    localparam int IW     = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic [NUM_TGT-1:0] cand,
    input  logic [IW-1:0]      ptr,
    output logic               found,
    output logic [IW-1:0]      idx
);
    logic [NUM_TGT-1:0] at_or_above;
    logic               hi_found;
    logic               all_found;
    logic [IW-1:0]      hi_idx;
    logic [IW-1:0]      all_idx;

    // keep candidates whose id is not below the pointer
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_win
        assign at_or_above[t] = cand[t] & (32'(t) >= 32'(ptr));
    end

    intr_low_pick #(.WIDTH(NUM_TGT)) u_hi (
        .bits  (at_or_above),
        .found (hi_found),
        .idx   (hi_idx)
    );

    intr_low_pick #(.WIDTH(NUM_TGT)) u_all (
        .bits  (cand),
        .found (all_found),
        .idx   (all_idx)
    );

    // prefer the upper window, wrap to the whole set otherwise
    assign found = hi_found | all_found;
    assign idx   = hi_found ? hi_idx : all_idx;
endmodule

// File: rtl/intr_dispatch.sv
// Interrupt target dispatcher: accepts one delivery request, resolves its
// target set and issues one injection per chosen target over ready/valid.
// Assumes the hit inputs are valid in the accepting cycle only; they are
// not looked at afterwards. A request is taken only when nothing is pending.
module intr_dispatch
    import intr_dispatch_pkg::*;
#(
    parameter int NUM_TGT = 32,
    parameter int VEC_W   = 8,
    parameter int DEST_W  = 8,
    localparam int TID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VEC_W-1:0]   req_vector,
    input  logic [DEST_W-1:0]  req_dest,
    input  logic               req_dest_logical,
    input  logic [2:0]         req_mode,
    input  logic               req_level,
    input  logic [NUM_TGT-1:0] tgt_present,
    input  logic [NUM_TGT-1:0] tgt_phys_hit,
    input  logic [NUM_TGT-1:0] tgt_logic_hit,
    output logic               inj_valid,
    input  logic               inj_ready,
    output logic [TID_W-1:0]   inj_target,
    output logic [VEC_W-1:0]   inj_vector,
    output logic               inj_level
);
    logic [NUM_TGT-1:0] req_set;
    logic [NUM_TGT-1:0] load_set;
    logic [NUM_TGT-1:0] pend_q;
    logic [TID_W-1:0]   rr_ptr_q;
    logic               rr_found;
    logic [TID_W-1:0]   rr_idx;
    logic               issue_found;
    logic [TID_W-1:0]   issue_idx;
    logic [VEC_W-1:0]   vec_q;
    logic               level_q;
    logic               accept;
    logic               fire;

    intr_target_mask #(.NUM_TGT(NUM_TGT), .DEST_W(DEST_W)) u_mask (
        .dest      (req_dest),
        .logical   (req_dest_logical),
        .present   (tgt_present),
        .phys_hit  (tgt_phys_hit),
        .logic_hit (tgt_logic_hit),
        .mask      (req_set)
    );

    intr_rr_pick #(.NUM_TGT(NUM_TGT)) u_rr (
        .cand  (req_set),
        .ptr   (rr_ptr_q),
        .found (rr_found),
        .idx   (rr_idx)
    );

    intr_low_pick #(.WIDTH(NUM_TGT)) u_issue (
        .bits  (pend_q),
        .found (issue_found),
        .idx   (issue_idx)
    );

    assign req_ready  = (pend_q == '0);
    assign accept     = req_valid & req_ready;
    assign inj_valid  = issue_found;
    assign fire       = inj_valid & inj_ready;
    assign inj_target = issue_idx;
    assign inj_vector = vec_q;
    assign inj_level  = level_q;

    // pending set loaded on acceptance, per delivery mode
    always_comb begin
        unique case (req_mode)
            MODE_FIXED:  load_set = req_set;
            MODE_LOWEST: load_set = rr_found ? (NUM_TGT'(1) << rr_idx) : '0;
            default:     load_set = '0;
        endcase
    end

    // pending set: load on accept, retire the lowest member on each handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (accept) begin
            pend_q <= load_set;
        end else if (fire) begin
            pend_q <= pend_q & ~(NUM_TGT'(1) << issue_idx);
        end
    end

    // injection attributes captured with the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q   <= '0;
            level_q <= 1'b0;
        end else if (accept) begin
            vec_q   <= req_vector;
            level_q <= req_level;
        end
    end

    // rotating pointer moves past the target chosen by a lowest-priority pick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr_q <= '0;
        end else if (accept && (req_mode == MODE_LOWEST) && rr_found) begin
            rr_ptr_q <= (32'(rr_idx) == NUM_TGT - 1) ? '0 : rr_idx + 1'b1;
        end
    end
endmodule

// File: rtl/intr_dispatch_chk.sv
// Protocol checker for intr_dispatch, attached by bind.
// Assumes the port names of the dispatcher; tracks only request kind.
module intr_dispatch_chk
    import intr_dispatch_pkg::*;
#(
    parameter int NUM_TGT = 32,
    parameter int VEC_W   = 8,
    parameter int DEST_W  = 8,
    localparam int TID_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [VEC_W-1:0]   req_vector,
    input logic [DEST_W-1:0]  req_dest,
    input logic               req_dest_logical,
    input logic [2:0]         req_mode,
    input logic               req_level,
    input logic [NUM_TGT-1:0] tgt_present,
    input logic [NUM_TGT-1:0] tgt_phys_hit,
    input logic [NUM_TGT-1:0] tgt_logic_hit,
    input logic               inj_valid,
    input logic               inj_ready,
    input logic [TID_W-1:0]   inj_target,
    input logic [VEC_W-1:0]   inj_vector,
    input logic               inj_level
);
    logic acc;
    logic hs;
    logic lp_act;
    logic ph_act;

    assign acc = req_valid && req_ready;
    assign hs  = inj_valid && inj_ready;

    // remember whether the running request may issue at most one injection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lp_act <= 1'b0;
            ph_act <= 1'b0;
        end else if (acc) begin
            lp_act <= (req_mode == MODE_LOWEST);
            ph_act <= (req_mode == MODE_FIXED) && !req_dest_logical
                      && (req_dest != DEST_W'(DEST_ALL));
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !inj_valid));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inj_valid && !inj_ready) |=>
        (inj_valid && $stable(inj_target) && $stable(inj_vector) && $stable(inj_level)));

    assert_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hs |=> (!inj_valid || (inj_target > $past(inj_target))));

    assert_ignored_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (req_mode != MODE_FIXED) && (req_mode != MODE_LOWEST)) |=>
        (!inj_valid && req_ready));

    assert_logical_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_dest_logical && (req_dest == '0)) |=> !inj_valid);

    assert_single_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_act && hs) |=> !inj_valid);

    assert_single_phys_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_act && hs) |=> !inj_valid);
endmodule

bind intr_dispatch intr_dispatch_chk #(
    .NUM_TGT (NUM_TGT),
    .VEC_W   (VEC_W),
    .DEST_W  (DEST_W)
) u_chk (.*);

// File: tb/test_intr_dispatch.sv
`timescale 1ns/1ps
module test_intr_dispatch;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_vector = '0;
    logic [7:0]  req_dest = '0;
    logic        req_dest_logical = 1'b0;
    logic [2:0]  req_mode = '0;
    logic        req_level = 1'b0;
    logic [31:0] tgt_present = '0;
    logic [31:0] tgt_phys_hit = '0;
    logic [31:0] tgt_logic_hit = '0;
    logic        inj_valid;
    logic        inj_ready = 1'b0;
    logic [4:0]  inj_target;
    logic [7:0]  inj_vector;
    logic        inj_level;

    int n_chk = 0;
    int n_err = 0;
    int rr_ptr = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    intr_dispatch i_intr_dispatch (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // target set from the addressing rules (R2..R5)
    function automatic logic [31:0] ref_set(input logic [7:0] dest, input bit logical,
                                            input logic [31:0] pres, input logic [31:0] ph,
                                            input logic [31:0] lh);
        logic [31:0] s = '0;
        if (!logical) begin
            if (dest == 8'hFF) return pres;
            for (int i = 0; i < N; i++)
                if (pres[i] && ph[i]) begin
                    s[i] = 1'b1;
                    return s;
                end
            return s;
        end
        if (dest == 8'h00) return '0;
        return pres & lh;
    endfunction

    // one request, then collect and compare its injections under random stalls
    task automatic run_req(input logic [7:0] vec, input logic [7:0] dest, input bit logical,
                           input logic [2:0] mode, input bit lvl, input logic [31:0] pres,
                           input logic [31:0] ph, input logic [31:0] lh, input string tag);
        int exp_t[32];
        int cnt = 0;
        int k = 0;
        int guard = 0;
        logic [31:0] s;
        s = ref_set(dest, logical, pres, ph, lh);
        if (mode == 3'b000) begin
            for (int i = 0; i < N; i++) if (s[i]) begin exp_t[cnt] = i; cnt++; end
        end else if (mode == 3'b001 && s != '0) begin
            int pick = -1;
            for (int i = rr_ptr; i < N; i++) if (s[i] && pick < 0) pick = i;
            for (int i = 0; i < N; i++) if (s[i] && pick < 0) pick = i;
            exp_t[0] = pick;
            cnt = 1;
            rr_ptr = (pick + 1) % N;
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R10", {tag, " ready before request"}, int'(req_ready), 1);
        req_vector = vec; req_dest = dest; req_dest_logical = logical;
        req_mode = mode; req_level = lvl;
        tgt_present = pres; tgt_phys_hit = ph; tgt_logic_hit = lh;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        tgt_present = $urandom; tgt_phys_hit = $urandom; tgt_logic_hit = $urandom;
        if (cnt > 0)
            check(inj_valid == 1'b1, "R11", {tag, " first injection timing"}, int'(inj_valid), 1);
        while (k < cnt && guard < 400) begin
            inj_ready = (($urandom % 10) < 7);
            if (inj_valid && inj_ready) begin
                check(int'(inj_target) == exp_t[k], (mode == 3'b001) ? "R8" : "R7",
                      {tag, " target"}, int'(inj_target), exp_t[k]);
                check(inj_vector == vec && inj_level == lvl, "R7", {tag, " vector/trigger"},
                      int'({inj_level, inj_vector}), int'({lvl, vec}));
                k++;
            end
            @(negedge clk);
            guard++;
        end
        inj_ready = 1'b0;
        check(k == cnt, "R7", {tag, " injection count"}, k, cnt);
        check(inj_valid == 1'b0, (cnt == 0) ? "R6" : "R7", {tag, " no extra injection"},
              int'(inj_valid), 0);
        check(req_ready == 1'b1, "R10", {tag, " ready after last"}, int'(req_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: idle outputs under and after reset
        check(req_ready == 1'b1 && inj_valid == 1'b0, "R1", "reset outputs",
              int'({req_ready, inj_valid}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && inj_valid == 1'b0, "R1", "after reset",
              int'({req_ready, inj_valid}), 2);

        // R2 broadcast to present targets, fixed mode
        run_req(8'h41, 8'hFF, 1'b0, 3'b000, 1'b1, 32'h8000_0013, '0, '0, "R2 broadcast");
        // R3 only lowest matching present target, although several hit
        run_req(8'h52, 8'h07, 1'b0, 3'b000, 1'b0, 32'hFFFF_FFF0, 32'h0F00_0F0C, '0, "R3 first hit");
        // R3/R6 no present hit: dropped
        run_req(8'h53, 8'h07, 1'b0, 3'b000, 1'b0, 32'h0000_00F0, 32'h0000_000F, '0, "R6 phys empty");
        // R4 logical zero destination with hits: nothing
        run_req(8'h60, 8'h00, 1'b1, 3'b000, 1'b1, '1, '1, '1, "R4 logical zero");
        // R5 logical set gated by presence
        run_req(8'h61, 8'h30, 1'b1, 3'b000, 1'b1, 32'h7FFF_FFFF, '0, 32'hC000_1201, "R5 logical");
        // R8 rotation from pointer 0: 4, then 8, then wrap to 4
        run_req(8'h70, 8'h01, 1'b1, 3'b001, 1'b0, '1, '0, 32'h0000_0110, "R8 pick a");
        run_req(8'h71, 8'h01, 1'b1, 3'b001, 1'b0, '1, '0, 32'h0000_0110, "R8 pick b");
        run_req(8'h72, 8'h01, 1'b1, 3'b001, 1'b0, '1, '0, 32'h0000_0110, "R8 wrap");
        // R9 ignored mode with a full set leaves the pointer alone
        run_req(8'h73, 8'hFF, 1'b0, 3'b010, 1'b0, '1, '0, '0, "R9 mode 2");
        run_req(8'h74, 8'hFF, 1'b0, 3'b111, 1'b1, '1, '0, '0, "R9 mode 7");
        run_req(8'h75, 8'h01, 1'b1, 3'b001, 1'b0, '1, '0, 32'h0000_0110, "R9 pointer kept");
        // R6 lowest priority with empty set leaves the pointer alone
        run_req(8'h76, 8'h01, 1'b1, 3'b001, 1'b0, '0, '0, '1, "R6 lp empty");
        // R8 top target then wrap of pointer to 0
        run_req(8'h77, 8'hFF, 1'b0, 3'b001, 1'b1, 32'h8000_0000, '0, '0, "R8 top");
        run_req(8'h78, 8'hFF, 1'b0, 3'b001, 1'b1, 32'h8000_0001, '0, '0, "R8 after top");

        // random mix
        for (int r = 0; r < 300; r++) begin
            logic [7:0] d;
            logic [2:0] m;
            int sel = $urandom % 8;
            d = (sel == 0) ? 8'hFF : (sel == 1) ? 8'h00 : 8'($urandom);
            sel = $urandom % 8;
            m = (sel < 3) ? 3'b000 : (sel < 6) ? 3'b001 : 3'($urandom);
            run_req(8'($urandom), d, 1'($urandom), m, 1'($urandom),
                    $urandom & $urandom, $urandom & $urandom & $urandom, $urandom,
                    "R7/R8 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule